// File: doc/BRIEF.md
# Keyed Low-Speed Clock Source Selector

This block produces the slow timekeeping tick, a single-cycle enable in the system clock domain. The tick comes from one of two sources. The first is an external crystal tick, which passes through without division. The second is an internal RC oscillator tick. That tick goes through a fixed pre-divide and then a programmable divide by N+1. A second output gives a gated copy of the slow tick. Downstream logic can use it as a buffered clock-out enable.

Software controls the block through a small register interface. The interface has a write strobe, a byte address and a 32-bit data word. Read data is combinational from the address. The source-select register is guarded by an unlock key: a write to it changes nothing unless the upper half of the data word holds the key. Changing the source or the divider value restarts the division chain. This ensures that no period of the wrong length is ever emitted.

Top module: `slowclk_sel`

## Requirements
- R1: The control register at offset 0x00 holds the source select in bit 0: 1 picks the external tick, 0 picks the internal RC path. A read returns that bit in bit 0 and zero in bits 31:1, so the key field always reads back as zero.
- R2: A write to offset 0x00 updates the source select only when write-data bits 31:16 equal 0x16AA. With any other value in those bits, the register keeps its old value.
- R3: With the internal source selected, `slow_tick` is high for one cycle after the clock edge that samples the (N+1)·PRE_DIV-th `rc_tick` counted since the last restart. The count then starts again.
- R4: With the external source selected and no restart in progress, `slow_tick` equals `ext_tick` delayed by one cycle, with no division.
- R5: The divider register at offset 0x08 holds N in bits 4:0 and needs no key. It reads back zero-extended.
- R6: The gate register at offset 0x60 holds the clock-out enable in bit 0. `clkout_tick` copies the tick that `slow_tick` shows in the same cycle when that bit was set at the edge producing it; otherwise `clkout_tick` is low.
- R7: A change of the source select or of N restarts division. Ticks sampled on the first edge after the register update are discarded, no tick is emitted for that edge, and counting starts from zero.
- R8: After reset, the internal source is selected, N is 0, clock-out is disabled, and both tick outputs are low.
- R9: Writes to unmapped offsets change no register, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| ext_tick | input | 1 | External crystal tick enable |
| rc_tick | input | 1 | Internal RC oscillator tick enable |
| slow_tick | output | 1 | Selected and divided slow tick |
| clkout_tick | output | 1 | Gated copy of the slow tick |

## Verification
The bench builds the block with a pre-divide of 4 instead of the default 32. This cuts the longest internal period from 1024 to 128 RC ticks. At that length, the largest divider setting N=31 completes several full periods in a short run. It also brings restarts that land mid-count, in both the pre-divide and the programmable stage, within reach of random register writes. Random key patterns, unmapped offsets and source flips mix with directed checks on the key, readback and reset values.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    parameter int LSC_ADDR_W = 8;
    parameter int LSC_DATA_W = 32;
    parameter int LSC_DIV_W  = 5;
    parameter int LSC_KEY_W  = 16;

    parameter logic [LSC_ADDR_W-1:0] OFS_CTRL = 8'h00;
    parameter logic [LSC_ADDR_W-1:0] OFS_DIV  = 8'h08;
    parameter logic [LSC_ADDR_W-1:0] OFS_GATE = 8'h60;

    typedef struct packed {
        logic                 sel_ext;
        logic [LSC_DIV_W-1:0] div_n;
        logic                 gate_en;
    } lsc_cfg_t;

    typedef struct packed {
        logic                 sel_prev;
        logic [LSC_DIV_W-1:0] n_prev;
        logic [LSC_DIV_W-1:0] cnt;
        logic                 tick;
        logic                 clkout;
    } lsc_div_st_t;
endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
    import lsc_pkg::*;
#(
    parameter logic [LSC_KEY_W-1:0] KEY = 16'h16AA
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [LSC_ADDR_W-1:0] addr_i,
    input  logic [LSC_DATA_W-1:0] wdata_i,
    output logic [LSC_DATA_W-1:0] rdata_o,
    output lsc_cfg_t              cfg_o
);
    localparam int KEY_LSB = LSC_DATA_W - LSC_KEY_W;

    lsc_cfg_t cfg_d, cfg_q;
    logic     key_ok;
    logic     wdata_unused;

    assign key_ok       = (wdata_i[LSC_DATA_W-1:KEY_LSB] == KEY);
    assign wdata_unused = ^wdata_i;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (addr_i)
                OFS_CTRL: if (key_ok) cfg_d.sel_ext = wdata_i[0];
                OFS_DIV:  cfg_d.div_n   = wdata_i[LSC_DIV_W-1:0];
                OFS_GATE: cfg_d.gate_en = wdata_i[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_CTRL: rdata_o[0]             = cfg_q.sel_ext;
            OFS_DIV:  rdata_o[LSC_DIV_W-1:0] = cfg_q.div_n;
            OFS_GATE: rdata_o[0]             = cfg_q.gate_en;
            default:  ;
        endcase
    end

    assign cfg_o = cfg_q;

    // R2
    key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_CTRL && !key_ok) |=> $stable(cfg_q.sel_ext));

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i != OFS_CTRL && addr_i != OFS_DIV && addr_i != OFS_GATE)
        |=> $stable(cfg_q));
endmodule

// File: rtl/lsc_prediv.sv
module lsc_prediv #(
    parameter int PRE_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic tick_o
);
    generate
        if (PRE_DIV > 1) begin : g_cnt
            localparam int CW = $clog2(PRE_DIV);
            localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clr_i)       cnt_d = '0;
                else if (tick_i) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = tick_i && !clr_i && (cnt_q == LAST);
        end else begin : g_pass
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign tick_o     = tick_i && !clr_i;
        end
    endgenerate
endmodule

// File: rtl/lsc_divider.sv
module lsc_divider
    import lsc_pkg::*;
#(
    parameter int PRE_DIV = 32
) (
    input  logic     clk,
    input  logic     rst_n,
    input  lsc_cfg_t cfg_i,
    input  logic     ext_tick_i,
    input  logic     rc_tick_i,
    output logic     tick_o,
    output logic     clkout_o
);
    lsc_div_st_t s_d, s_q;
    logic        restart;
    logic        pre_tick;

    assign restart = (cfg_i.sel_ext != s_q.sel_prev) || (cfg_i.div_n != s_q.n_prev);

    lsc_prediv #(.PRE_DIV(PRE_DIV)) u_prediv (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (restart || cfg_i.sel_ext),
        .tick_i (rc_tick_i),
        .tick_o (pre_tick)
    );

    always_comb begin
        s_d          = s_q;
        s_d.sel_prev = cfg_i.sel_ext;
        s_d.n_prev   = cfg_i.div_n;
        s_d.tick     = 1'b0;
        if (restart) begin
            s_d.cnt = '0;
        end else if (cfg_i.sel_ext) begin
            s_d.cnt  = '0;
            s_d.tick = ext_tick_i;
        end else if (pre_tick) begin
            if (s_q.cnt == cfg_i.div_n) begin
                s_d.cnt  = '0;
                s_d.tick = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        s_d.clkout = s_d.tick && cfg_i.gate_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o   = s_q.tick;
    assign clkout_o = s_q.clkout;

    // R7
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_i.sel_ext != $past(cfg_i.sel_ext)) || (cfg_i.div_n != $past(cfg_i.div_n)))
        |=> !tick_o);

    // R4
    ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.sel_ext && $stable(cfg_i.sel_ext) && $stable(cfg_i.div_n))
        |=> (tick_o == $past(ext_tick_i)));

    // R3
    rc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.sel_ext && !rc_tick_i) |=> !tick_o);

    // R6
    clkout_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clkout_o |-> tick_o);
endmodule

// File: rtl/slowclk_sel.sv
module slowclk_sel
    import lsc_pkg::*;
#(
    parameter int                   PRE_DIV = 32,
    parameter logic [LSC_KEY_W-1:0] KEY     = 16'h16AA
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [LSC_ADDR_W-1:0] addr,
    input  logic [LSC_DATA_W-1:0] wdata,
    output logic [LSC_DATA_W-1:0] rdata,
    input  logic                  ext_tick,
    input  logic                  rc_tick,
    output logic                  slow_tick,
    output logic                  clkout_tick
);
    lsc_cfg_t cfg;

    lsc_regs #(.KEY(KEY)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .cfg_o   (cfg)
    );

    lsc_divider #(.PRE_DIV(PRE_DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg),
        .ext_tick_i (ext_tick),
        .rc_tick_i  (rc_tick),
        .tick_o     (slow_tick),
        .clkout_o   (clkout_tick)
    );
endmodule

// File: tb/sim_slowclk_sel.sv
module sim_slowclk_sel;
    localparam int PRE = 4;
    localparam logic [15:0] KEY = 16'h16AA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ext_tick = 1'b0;
    logic        rc_tick = 1'b0;
    logic        slow_tick;
    logic        clkout_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    bit       m_sel = 0, m_gate = 0, m_psel = 0;
    bit [4:0] m_n = 0, m_pn = 0;
    int       m_cnt = 0;
    bit       m_tick = 0, m_clk = 0;
    string    m_tag = "R8";

    always #10 clk = ~clk;

    slowclk_sel #(.PRE_DIV(PRE), .KEY(KEY)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_tick(ext_tick), .rc_tick(rc_tick),
        .slow_tick(slow_tick), .clkout_tick(clkout_tick)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return {31'b0, m_sel};
            8'h08:   return {27'b0, m_n};
            8'h60:   return {31'b0, m_gate};
            default: return 32'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        addr = a; wr_en = 1'b0;
        #1;
        chk(tag, rdata, exp_read(a));
    endtask

    // one clock: drive at negedge, model the edge, check at next negedge
    task automatic cyc(input bit e, input bit r, input bit w, input logic [7:0] a,
                       input logic [31:0] d);
        bit restart;
        ext_tick = e; rc_tick = r; wr_en = w; addr = a; wdata = d;
        restart = (m_sel != m_psel) || (m_n != m_pn);
        m_tick = 0;
        if (restart) begin
            m_cnt = 0; m_tag = "R7";
        end else if (m_sel) begin
            m_cnt = 0; m_tick = e; m_tag = "R4";
        end else begin
            m_tag = "R3";
            if (r) begin
                m_cnt++;
                if (m_cnt == (int'(m_n) + 1) * PRE) begin
                    m_cnt = 0; m_tick = 1;
                end
            end
        end
        m_clk  = m_tick && m_gate;
        m_psel = m_sel; m_pn = m_n;
        if (w) begin
            case (a)
                8'h00: if (d[31:16] == KEY) m_sel = d[0];
                8'h08: m_n = d[4:0];
                8'h60: m_gate = d[0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk(m_tag, {31'b0, slow_tick}, {31'b0, m_tick});
        chk("R6", {31'b0, clkout_tick}, {31'b0, m_clk});
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        #35;
        // R8 reset state
        chk("R8", {30'b0, slow_tick, clkout_tick}, 32'b0);
        rd_chk(8'h00, "R8");
        rd_chk(8'h08, "R8");
        rd_chk(8'h60, "R8");
        rst_n = 1'b1;
        @(negedge clk);

        // R3 internal N=0: period PRE with continuous rc ticks
        for (int i = 0; i < 3 * PRE; i++) cyc(0, 1, 0, 8'h00, 0);

        // R2 wrong key rejected
        cyc(0, 0, 1, 8'h00, 32'h1234_0001);
        rd_chk(8'h00, "R2");
        // R1 right key accepted, key field reads zero
        cyc(0, 0, 1, 8'h00, {KEY, 16'hFFFF});
        rd_chk(8'h00, "R1");
        chk("R1", rdata, 32'h1);
        // R4 external pass-through
        for (int i = 0; i < 20; i++) cyc(i % 3 != 0, 1, 0, 8'h00, 0);
        // R5 divider write and readback
        cyc(1, 0, 1, 8'h08, 32'hFFFF_FFFF);
        rd_chk(8'h08, "R5");
        chk("R5", rdata, 32'h1F);
        // R6 gate on
        cyc(1, 0, 1, 8'h60, 32'h1);
        rd_chk(8'h60, "R6");
        // R9 unmapped write and read
        cyc(1, 0, 1, 8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, "R9");
        rd_chk(8'h00, "R9");
        rd_chk(8'h08, "R9");
        rd_chk(8'h60, "R9");
        // back to internal at N=31: long periods, R3 and R7
        cyc(1, 1, 1, 8'h00, {KEY, 16'h0000});
        for (int i = 0; i < 400; i++) cyc(1, 1, 0, 8'h00, 0);
        // R7 mid-count divider change
        cyc(0, 1, 1, 8'h08, 32'h2);
        for (int i = 0; i < 60; i++) cyc(0, 1, 0, 8'h00, 0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            bit e, r, w;
            logic [7:0]  a;
            logic [31:0] d;
            e = ($urandom % 10) < 3;
            r = ($urandom % 2) == 1;
            w = ($urandom % 40) == 0;
            case ($urandom % 4)
                0: a = 8'h00;
                1: a = 8'h08;
                2: a = 8'h60;
                default: a = 8'h04;
            endcase
            d = $urandom;
            if ($urandom % 2) d[31:16] = KEY;
            if (a == 8'h08) d[4:0] = 5'($urandom % 8);
            cyc(e, r, w, a, d);
            if ((i % 250) == 0) rd_chk(a, a == 8'h00 ? "R1" : a == 8'h08 ? "R5" :
                                          a == 8'h60 ? "R6" : "R9");
        end
        done = 1;
        report();
    end
endmodule